// File: doc/BRIEF.md
# Dual-Convention Host Register Bus Slave

This block sits between a 16-bit host processor bus and a small bank of internal registers. The host places a register address on the address lines, strobes an address-latch enable, and then performs a read or a write under an active-low chip select. The block works out the kind of access from two bus-control lines. How it reads them depends on a convention-select pin, which may change between bus cycles.

With the convention pin high, `wen` is an active-high access enable and `rw` chooses the direction. With it low, `rw` and `wen` are separate active-low read and write strobes. Writes are sampled into the system clock through a synchroniser and commit once, when the effective write strobe ends. A write-timing pin can hold the internal write off for as long as the address-latch enable is high, which gives the latched address time to settle. Reads drive the data bus through a separate output-enable, so the pad ring can build the tri-state buffer.

The default map has four 16-bit registers at addresses 0x20 to 0x23. Every other address reads as zero, and writes to it are dropped. If both strobes go low together under the strobe-pair convention, the block performs no access and sets a sticky error flag.

Top module: `hbus_host_if`

## Requirements
- R1: After the active-low `rst_n` is released, `proto_err` is 0, `data_oe` is 0 and every mapped register reads back as 0x0000.
- R2: With `proto_sel`=1, `wen`=1 and `rw`=0 under `cs_n`=0 is a write, and `wen`=1 with `rw`=1 is a read that drives the register at the latched address with `data_oe`=1.
- R3: With `proto_sel`=0, `rw`=0 and `wen`=1 is a read, and `wen`=0 and `rw`=1 is a write.
- R4: While `cs_n`=1, no strobe pattern writes a register or raises `data_oe`.
- R5: `addr_in` is captured on every clock edge at which `ale`=1 and is held while `ale`=0. `addr_in[0]` is the least significant address bit. A change of `addr_in` after `ale` falls does not alter the register being accessed.
- R6: A write commits `data_in` exactly once, in the clock cycles after its effective strobe ends. `data_in` activity after the commit, while no write strobe is asserted, leaves the register unchanged.
- R7: With `wr_delay`=1, the internal write is inactive whenever `ale`=1, so a strobe that lies entirely inside an `ale` pulse writes nothing. A strobe that outlasts `ale` writes after `ale` falls. With `wr_delay`=0, a strobe during `ale`=1 writes normally.
- R8: With `proto_sel`=0, `cs_n`=0 and both `wen` and `rw` low, no access occurs (`data_oe`=0, no write). `proto_err` goes to 1 within three clock cycles and stays at 1 until reset.
- R9: Addresses outside 0x20..0x23 read as 0x0000 with `data_oe`=1, and writes to them change no register.
- R10: Whenever `data_oe`=0, `data_out` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| proto_sel | input | 1 | Bus convention: 1 = enable plus direction, 0 = separate active-low strobes |
| wr_delay | input | 1 | 1 = hold the internal write off while `ale` is high |
| ale | input | 1 | Address latch enable, active high |
| cs_n | input | 1 | Chip select, active low |
| wen | input | 1 | Bus control line (enable or write strobe) |
| rw | input | 1 | Bus control line (direction or read strobe) |
| addr_in | input | 8 | Register address, bit 0 least significant |
| data_in | input | 16 | Write data from host |
| data_out | output | 16 | Read data toward host |
| data_oe | output | 1 | Data bus output enable |
| proto_err | output | 1 | Sticky flag for both strobes low together |

## Verification
The hardest cases to reach are the overlaps between `ale` and the write strobe. The write-delay mode only shows an effect when the strobe starts while the address latch is still open. The stimulus therefore drives hand-timed cycles: one strobe lies wholly inside an `ale` pulse and another outlasts it, each run with `wr_delay` both high and low, and the results are read back through normal reads. The illegal double-strobe case is driven with both lines falling and rising in the same step. This keeps a single strobe from passing through as a valid access.

// File: rtl/hbus_pkg.sv
`timescale 1ns/1ps
package hbus_pkg;
  localparam int HB_DATA_W = 16;
  localparam int HB_ADDR_W = 8;
  localparam int HB_NUM_REGS = 4;
  localparam int HB_SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    ACC_IDLE    = 2'd0,
    ACC_READ    = 2'd1,
    ACC_WRITE   = 2'd2,
    ACC_ILLEGAL = 2'd3
  } acc_e;
endpackage

// File: rtl/hbus_decode.sv
`timescale 1ns/1ps
module hbus_decode
  import hbus_pkg::*;
(
  input  logic cs_n,
  input  logic proto_sel,
  input  logic wen,
  input  logic rw,
  input  logic ale,
  input  logic wr_delay,
  output logic rd_act,
  output logic wr_eff,
  output logic bad_act
);
  acc_e kind;

  // Access kind from the control lines, per convention
  always_comb begin
    kind = ACC_IDLE;
    if (proto_sel) begin
      if (wen) kind = rw ? ACC_READ : ACC_WRITE;
    end else begin
      unique case ({wen, rw})
        2'b10:   kind = ACC_READ;
        2'b01:   kind = ACC_WRITE;
        2'b00:   kind = ACC_ILLEGAL;
        default: kind = ACC_IDLE;
      endcase
    end
  end

  always_comb begin
    rd_act  = !cs_n && (kind == ACC_READ);
    // write held off while the latch is open, when requested
    wr_eff  = !cs_n && (kind == ACC_WRITE) && !(wr_delay && ale);
    bad_act = !cs_n && (kind == ACC_ILLEGAL);
  end
endmodule

// File: rtl/hbus_sync.sv
`timescale 1ns/1ps
module hbus_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st   [STAGES];
  logic [W-1:0] st_nxt [STAGES];

  always_comb begin
    st_nxt[0] = d;
    for (int k = 1; k < STAGES; k++) st_nxt[k] = st[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) st[k] <= '0;
    end else begin
      for (int k = 0; k < STAGES; k++) st[k] <= st_nxt[k];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/hbus_regfile.sv
`timescale 1ns/1ps
module hbus_regfile #(
  parameter int DW   = 16,
  parameter int AW   = 8,
  parameter int NREG = 4,
  parameter logic [AW-1:0] BASE = 8'h20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [NREG*DW-1:0] flat;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [AW-1:0] MY_ADDR = BASE + AW'(i);
    logic [DW-1:0] q;
    logic [DW-1:0] q_nxt;
    logic          hit;

    always_comb begin
      hit   = wr_en && (wr_addr == MY_ADDR);
      q_nxt = hit ? wr_data : q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= q_nxt;
    end

    assign flat[i*DW +: DW] = q;
  end

  // Unmapped addresses fall through to zero
  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NREG; k++) begin
      if (rd_addr == BASE + AW'(k)) rd_data = flat[k*DW +: DW];
    end
  end
endmodule

// File: rtl/hbus_host_if.sv
`timescale 1ns/1ps
module hbus_host_if
  import hbus_pkg::*;
#(
  parameter int DATA_W   = HB_DATA_W,
  parameter int ADDR_W   = HB_ADDR_W,
  parameter int NUM_REGS = HB_NUM_REGS,
  parameter int SYNC_N   = HB_SYNC_STAGES,
  parameter logic [ADDR_W-1:0] REG_BASE = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              proto_sel,
  input  logic              wr_delay,
  input  logic              ale,
  input  logic              cs_n,
  input  logic              wen,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic              proto_err
);
  logic              rst_q_n;
  logic              rd_act, wr_eff, bad_act;
  logic [1:0]        sync_q;
  logic              wr_s, bad_s;
  logic              wr_s_d, wr_s_d_nxt;
  logic              wr_commit;
  logic [ADDR_W-1:0] addr_q, addr_nxt;
  logic [DATA_W-1:0] wdata_q, wdata_nxt;
  logic              err_q, err_nxt;
  logic [DATA_W-1:0] rd_data;

  // Reset asserted asynchronously, released on the clock
  hbus_sync #(.W(1), .STAGES(SYNC_N)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_q_n)
  );

  hbus_decode u_decode (
    .cs_n(cs_n), .proto_sel(proto_sel), .wen(wen), .rw(rw),
    .ale(ale), .wr_delay(wr_delay),
    .rd_act(rd_act), .wr_eff(wr_eff), .bad_act(bad_act)
  );

  hbus_sync #(.W(2), .STAGES(SYNC_N)) u_strobe_sync (
    .clk(clk), .rst_n(rst_q_n), .d({bad_act, wr_eff}), .q(sync_q)
  );
  assign {bad_s, wr_s} = sync_q;

  always_comb begin
    addr_nxt   = ale ? addr_in : addr_q;
    wdata_nxt  = wr_s ? data_in : wdata_q;
    wr_s_d_nxt = wr_s;
    err_nxt    = err_q | bad_s;
    wr_commit  = wr_s_d && !wr_s;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_s_d  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      addr_q  <= addr_nxt;
      wdata_q <= wdata_nxt;
      wr_s_d  <= wr_s_d_nxt;
      err_q   <= err_nxt;
    end
  end

  hbus_regfile #(
    .DW(DATA_W), .AW(ADDR_W), .NREG(NUM_REGS), .BASE(REG_BASE)
  ) u_regs (
    .clk(clk), .rst_n(rst_q_n), .wr_en(wr_commit), .wr_addr(addr_q),
    .wr_data(wdata_q), .rd_addr(addr_q), .rd_data(rd_data)
  );

  assign data_oe   = rd_act;
  assign data_out  = rd_act ? rd_data : '0;
  assign proto_err = err_q;
endmodule

// File: rtl/hbus_host_if_chk.sv
`timescale 1ns/1ps
module hbus_host_if_chk #(
  parameter int DW   = 16,
  parameter int AW   = 8,
  parameter int NREG = 4,
  parameter logic [AW-1:0] BASE = 8'h20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          proto_sel,
  input logic          wen,
  input logic          rw,
  input logic          ale,
  input logic          data_oe,
  input logic [DW-1:0] data_out,
  input logic          proto_err,
  input logic [AW-1:0] addr_q,
  input logic          wr_commit
);
  logic unmapped;
  assign unmapped = (addr_q < BASE) || ({1'b0, addr_q} >= ({1'b0, BASE} + (AW+1)'(NREG)));

  AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> !cs_n); // R4
  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> (data_out == '0)); // R10
  AST_ILLEGAL_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !proto_sel && !wen && !rw) |-> !data_oe); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err); // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && unmapped) |-> (data_out == '0)); // R9
  AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit); // R6
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !ale |=> $stable(addr_q)); // R5
endmodule

bind hbus_host_if hbus_host_if_chk #(
  .DW(DATA_W), .AW(ADDR_W), .NREG(NUM_REGS), .BASE(REG_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .proto_sel(proto_sel),
  .wen(wen), .rw(rw), .ale(ale), .data_oe(data_oe), .data_out(data_out),
  .proto_err(proto_err), .addr_q(addr_q), .wr_commit(wr_commit)
);

// File: tb/hbus_host_if_tb.sv
`timescale 1ns/1ps
module hbus_host_if_tb;
  logic        clk = 1'b0;
  logic        rst_n, proto_sel, wr_delay, ale, cs_n, wen, rw;
  logic [7:0]  addr_in;
  logic [15:0] data_in, data_out;
  logic        data_oe, proto_err;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hbus_host_if u_dut (
    .clk(clk), .rst_n(rst_n), .proto_sel(proto_sel), .wr_delay(wr_delay),
    .ale(ale), .cs_n(cs_n), .wen(wen), .rw(rw), .addr_in(addr_in),
    .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .proto_err(proto_err)
  );

  typedef struct packed {
    logic        mode;   // 1 = enable/direction, 0 = strobe pair
    logic        is_wr;
    logic [7:0]  a;
    logic [15:0] d;      // write data or expected read data
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b1, 8'h20, 16'h1111},
    '{1'b0, 1'b1, 8'h21, 16'h2222},
    '{1'b1, 1'b1, 8'h22, 16'h3333},
    '{1'b0, 1'b1, 8'h23, 16'h4444},
    '{1'b1, 1'b1, 8'h40, 16'h5555},
    '{1'b1, 1'b0, 8'h20, 16'h1111},
    '{1'b0, 1'b0, 8'h21, 16'h2222},
    '{1'b0, 1'b0, 8'h22, 16'h3333},
    '{1'b1, 1'b0, 8'h23, 16'h4444},
    '{1'b0, 1'b0, 8'h40, 16'h0000},
    '{1'b1, 1'b0, 8'h1F, 16'h0000}
  };

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic idle_strobes();
    wen = proto_sel ? 1'b0 : 1'b1;
    rw  = 1'b1;
  endtask

  task automatic set_wr();
    if (proto_sel) begin wen = 1'b1; rw = 1'b0; end
    else           begin wen = 1'b0; rw = 1'b1; end
  endtask

  task automatic set_rd();
    if (proto_sel) begin wen = 1'b1; rw = 1'b1; end
    else           begin wen = 1'b1; rw = 1'b0; end
  endtask

  task automatic latch_addr(logic [7:0] a);
    ale = 1'b1; addr_in = a;
    step(2);
    ale = 1'b0;
    step(1);
  endtask

  task automatic do_write(logic mode, logic [7:0] a, logic [15:0] d);
    proto_sel = mode; idle_strobes();
    latch_addr(a);
    data_in = d; cs_n = 1'b0; set_wr();
    step(3);
    idle_strobes();
    step(5);
    cs_n = 1'b1;
    step(1);
  endtask

  task automatic do_read(logic mode, logic [7:0] a, output logic [15:0] d, output logic oe);
    proto_sel = mode; idle_strobes();
    latch_addr(a);
    cs_n = 1'b0; set_rd();
    step(1);
    @(negedge clk);
    d = data_out; oe = data_oe;
    idle_strobes(); cs_n = 1'b1;
    step(1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(4);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    logic        oe;
    proto_sel = 1'b1; wr_delay = 1'b1; ale = 1'b0; cs_n = 1'b1;
    wen = 1'b0; rw = 1'b1; addr_in = '0; data_in = '0;
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(4);

    // R1 / R10: reset state
    @(negedge clk);
    check("R1 oe after reset", {15'd0, data_oe}, 16'd0);
    check("R1 err after reset", {15'd0, proto_err}, 16'd0);
    check("R10 bus idle zero", data_out, 16'h0000);
    step(1);
    do_read(1'b1, 8'h20, rd, oe);
    check("R1 reg cleared", rd, 16'h0000);

    // Table walk: R2 (mode A), R3 (mode B), R9 (unmapped)
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].is_wr) begin
        do_write(VEC[i].mode, VEC[i].a, VEC[i].d);
      end else begin
        do_read(VEC[i].mode, VEC[i].a, rd, oe);
        check(VEC[i].mode ? "R2 read data" : "R3 read data", rd, VEC[i].d);
        check((VEC[i].a == 8'h40 || VEC[i].a == 8'h1F) ? "R9 oe on unmapped" : "R2 R3 oe on read",
              {15'd0, oe}, 16'd1);
      end
    end

    // R4: strobes with chip select high
    proto_sel = 1'b1; idle_strobes();
    latch_addr(8'h20);
    data_in = 16'hAAAA; cs_n = 1'b1; set_wr();
    step(3);
    idle_strobes();
    step(5);
    set_rd();
    step(1);
    @(negedge clk);
    check("R4 no oe without cs", {15'd0, data_oe}, 16'd0);
    check("R10 bus zero without oe", data_out, 16'h0000);
    idle_strobes();
    step(1);
    do_read(1'b1, 8'h20, rd, oe);
    check("R4 no write without cs", rd, 16'h1111);

    // R5: address change after ale falls is ignored
    proto_sel = 1'b1; idle_strobes();
    latch_addr(8'h21);
    addr_in = 8'h20;
    cs_n = 1'b0; set_rd();
    step(2);
    @(negedge clk);
    check("R5 latched address held", data_out, 16'h2222);
    idle_strobes(); cs_n = 1'b1;
    step(1);

    // R6: data activity after commit does not rewrite
    do_write(1'b0, 8'h20, 16'h0F0F);
    proto_sel = 1'b1; idle_strobes();
    cs_n = 1'b0; data_in = 16'hFFFF;
    step(5);
    cs_n = 1'b1;
    step(1);
    do_read(1'b1, 8'h20, rd, oe);
    check("R6 single commit", rd, 16'h0F0F);

    // R7: strobe entirely inside ale, write delay on -> no write
    wr_delay = 1'b1; proto_sel = 1'b1; idle_strobes();
    ale = 1'b1; addr_in = 8'h22; data_in = 16'hDEAD; cs_n = 1'b0; set_wr();
    step(4);
    idle_strobes();
    step(2);
    ale = 1'b0;
    step(4);
    cs_n = 1'b1;
    step(1);
    do_read(1'b1, 8'h22, rd, oe);
    check("R7 write held off under ale", rd, 16'h3333);

    // R7: same pattern with write delay off -> writes
    wr_delay = 1'b0; proto_sel = 1'b1; idle_strobes();
    ale = 1'b1; addr_in = 8'h22; data_in = 16'hDEAD; cs_n = 1'b0; set_wr();
    step(4);
    idle_strobes();
    step(2);
    ale = 1'b0;
    step(4);
    cs_n = 1'b1;
    step(1);
    do_read(1'b1, 8'h22, rd, oe);
    check("R7 no delay writes under ale", rd, 16'hDEAD);

    // R7: strobe outlasting ale with write delay on -> writes
    wr_delay = 1'b1; proto_sel = 1'b1; idle_strobes();
    ale = 1'b1; addr_in = 8'h23; data_in = 16'hBEEF; cs_n = 1'b0; set_wr();
    step(3);
    ale = 1'b0;
    step(4);
    idle_strobes();
    step(5);
    cs_n = 1'b1;
    step(1);
    do_read(1'b0, 8'h23, rd, oe);
    check("R7 write after ale falls", rd, 16'hBEEF);

    // R8: both strobes low in strobe-pair convention
    proto_sel = 1'b0; idle_strobes();
    latch_addr(8'h21);
    data_in = 16'h9999; cs_n = 1'b0; wen = 1'b0; rw = 1'b0;
    step(1);
    @(negedge clk);
    check("R8 no oe on illegal", {15'd0, data_oe}, 16'd0);
    step(3);
    @(negedge clk);
    check("R8 err raised", {15'd0, proto_err}, 16'd1);
    wen = 1'b1; rw = 1'b1;
    step(5);
    cs_n = 1'b1;
    step(1);
    do_read(1'b0, 8'h21, rd, oe);
    check("R8 no write on illegal", rd, 16'h2222);
    @(negedge clk);
    check("R8 err sticky", {15'd0, proto_err}, 16'd1);

    // R1: reset clears flag and registers
    do_reset();
    @(negedge clk);
    check("R1 err cleared by reset", {15'd0, proto_err}, 16'd0);
    step(1);
    do_read(1'b1, 8'h23, rd, oe);
    check("R1 reg cleared by reset", rd, 16'h0000);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule